// File: doc/BRIEF.md
# Floppy controller command sequencer

This block sits on a processor's peripheral bus and imitates the host-visible protocol of a floppy disk controller. Software writes a command as a string of bytes into one data port, and the block collects as many bytes as the opcode calls for. It then executes the command in one clock cycle. If the command returns anything, software pulls the result bytes back out of the same port. A main status register tells software whether the block accepts a byte, which way the next transfer goes, and whether a command is in progress.

Execution is modelled rather than performed. Seek records the new cylinder. Recalibrate, sense interrupt status, read ID and read data build the status and geometry bytes a real controller would return. Undefined opcodes report an invalid command. No media timing, head motion or sector data transfer is modelled. A control port holds the drive select, the motor enables and the interrupt/DMA enable, and its active-low reset bit starts a soft reset. A separate port drives a pin-level hard reset. The interrupt flag is visible on a pin and through a status port.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After synchronous reset the main status register reads 0x80, the interrupt status port reads 0x00, the irq pin is low, and drive_sel, motor_on and dma_irq_en are zero. In the main status register, bit 7 is ready, bit 6 is data-in direction and bit 5 is busy.
- R2: In idle, the first data-port write selects the opcode from its low 5 bits, and bits 7:5 are ignored. Command and result lengths then follow this table:
  - opcodes 0x02, 0x05, 0x06, 0x09, 0x0C, 0x11, 0x19, 0x1D take 9 bytes and return 7;
  - 0x03 and 0x0F take 3 and return 0;
  - 0x04 takes 2 and returns 1;
  - 0x07 takes 2 and returns 0;
  - 0x08 takes 1 and returns 2;
  - 0x0A takes 2 and returns 7;
  - 0x0D takes 6 and returns 7;
  - every other opcode takes 1 and returns 1.
- R3: The main status register reads 0xA0 while command bytes are being collected, 0x20 in the single execution cycle that follows the last command byte, 0xE0 while result bytes are pending and 0x80 when idle.
- R4: A data-port write during the execution cycle or the result phase is dropped and changes neither the results nor the phase.
- R5: Each data-port read in the result phase returns the next result byte in order, and after the last one the block is idle (0x80). A data-port read with no pending result leaves the read data unchanged and does not alter the phase.
- R6: An undefined opcode returns one byte, 0x80 (invalid command), which also becomes the stored ST0. Opcodes 0x02, 0x03, 0x04, 0x05, 0x09, 0x0C, 0x0D, 0x11, 0x19 and 0x1D change nothing. When they have results, the first byte is the stored ST0 and the rest are 0x00.
- R7: Seek (0x0F) takes its third byte as the new cylinder and sets ST0 to 0x20. Recalibrate (0x07) sets ST0 to 0x20 when bits 1:0 of its second byte are 0, and to 0x60 otherwise. Neither command returns result bytes.
- R8: Sense interrupt status (0x08) returns ST0 followed by the present cylinder. ST0 is 0xC0 when drive 0 is selected and 0x60 otherwise.
- R9: Read data (0x06) uses byte 2 as cylinder, byte 3 as head, byte 4 as record and byte 5 as size. It returns 0x00, 0x00, 0x00, then the next cylinder, head and record, then the size. The record is incremented; past 18 it returns to 1 and the head advances; past head 1 the head returns to 0 and the cylinder advances; past cylinder 79 the cylinder returns to 0.
- R10: Read ID (0x0A) returns 0x00, 0x00, 0x00, the present cylinder, 0x00, 0x01, 0x02, and clears the stored ST0.
- R11: A control-port write sets motor_on from bits 5:4, dma_irq_en from bit 3 and drive_sel from bits 1:0. Bit 2 is an active-low reset:
  - driving it low after it was high clears the interrupt;
  - raising it again after it was low performs a soft reset, which returns the block to idle and clears ST0;
  - the soft reset raises the interrupt only when bits 1:0 are 0.
- R12: Setting bit 6 of the pin-reset port after it was clear clears the interrupt. Clearing it afterwards performs a hard reset, which returns the block to idle, clears ST0 and zeroes drive_sel, motor_on and dma_irq_en.
- R13: Port map:
  - address 0 is the data port and address 1 the main status register;
  - address 2 is the control port and address 3 the pin reset;
  - address 4 is interrupt status, reading 0x40 when the interrupt is pending and 0x00 otherwise;
  - address 5 always reads 0x40 (transfer request);
  - any other read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W | Port select |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data, valid the cycle after rd_en |
| irq | output | 1 | Interrupt pending |
| drive_sel | output | 2 | Selected drive |
| motor_on | output | 2 | Motor enables for drives B and A |
| dma_irq_en | output | 1 | Interrupt and DMA enable |

## Verification
The bench builds the block with its defaults: 18 records, 2 heads and 80 cylinders, a 9-byte command buffer and a 7-byte result buffer. With these values every wrap of the read-data geometry is reached, including the full cylinder roll-over from 79 to 0. The 5-bit opcode field also lets random commands cover all 32 table entries. The table's longest entries fill the command and result buffers exactly, so the last-index boundaries of both buffers are exercised.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

  typedef logic [7:0] byte_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_CMD    = 2'd1,
    PH_EXEC   = 2'd2,
    PH_RESULT = 2'd3
  } phase_t;

  // Port numbers on the host bus
  localparam int unsigned PORT_DATA   = 0;
  localparam int unsigned PORT_MSR    = 1;
  localparam int unsigned PORT_CTRL   = 2;
  localparam int unsigned PORT_PINRST = 3;
  localparam int unsigned PORT_IRQ    = 4;
  localparam int unsigned PORT_DRQ    = 5;

  // Opcodes with a modelled action
  localparam logic [4:0] OP_READ_DATA = 5'h06;
  localparam logic [4:0] OP_RECAL     = 5'h07;
  localparam logic [4:0] OP_SENSE_INT = 5'h08;
  localparam logic [4:0] OP_READ_ID   = 5'h0A;
  localparam logic [4:0] OP_SEEK      = 5'h0F;

  // ST0 codes
  localparam byte_t ST0_SEEK_END = 8'h20;
  localparam byte_t ST0_ABNORMAL = 8'h40;
  localparam byte_t ST0_INVALID  = 8'h80;

  // Main status bits
  localparam byte_t MSR_READY = 8'h80;
  localparam byte_t MSR_DIN   = 8'h40;
  localparam byte_t MSR_BUSY  = 8'h20;

  // Packed {command length, result length} for an opcode
  function automatic logic [7:0] op_lengths(input logic [4:0] op);
    case (op)
      5'h02, 5'h05, 5'h06, 5'h09,
      5'h0C, 5'h11, 5'h19, 5'h1D: op_lengths = {4'd9, 4'd7};
      5'h03, 5'h0F:               op_lengths = {4'd3, 4'd0};
      5'h04:                      op_lengths = {4'd2, 4'd1};
      5'h07:                      op_lengths = {4'd2, 4'd0};
      5'h08:                      op_lengths = {4'd1, 4'd2};
      5'h0A:                      op_lengths = {4'd2, 4'd7};
      5'h0D:                      op_lengths = {4'd6, 4'd7};
      default:                    op_lengths = {4'd1, 4'd1};
    endcase
  endfunction

  function automatic logic op_undefined(input logic [4:0] op);
    op_undefined = (op_lengths(op) == {4'd1, 4'd1});
  endfunction

endpackage

// File: rtl/fdc_op_table.sv
module fdc_op_table
  import fdc_seq_pkg::*;
#(
  parameter int OPS   = 32,
  parameter int LEN_W = 4,
  parameter int OP_W  = $clog2(OPS)
) (
  input  logic [OP_W-1:0]  op,
  output logic [LEN_W-1:0] cmd_len,
  output logic [LEN_W-1:0] res_len
);

  logic [LEN_W-1:0] clen_rom [OPS];
  logic [LEN_W-1:0] rlen_rom [OPS];

  for (genvar i = 0; i < OPS; i++) begin : g_rom
    localparam logic [7:0] ENTRY = op_lengths(5'(i));
    assign clen_rom[i] = LEN_W'(ENTRY[7:4]);
    assign rlen_rom[i] = LEN_W'(ENTRY[3:0]);
  end

  assign cmd_len = clen_rom[op];
  assign res_len = rlen_rom[op];

  always_comb begin
    a_r2_len_nonzero: assert (cmd_len != '0);
  end

endmodule

// File: rtl/fdc_cmd_store.sv
module fdc_cmd_store
  import fdc_seq_pkg::*;
#(
  parameter int DEPTH = 9,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [IDX_W-1:0]        widx,
  input  byte_t                   wdata,
  output byte_t [DEPTH-1:0]       bytes_o
);

  byte_t [DEPTH-1:0] mem_q;

  always_ff @(posedge clk) begin
    if (we) mem_q[widx] <= wdata;
  end

  assign bytes_o = mem_q;

endmodule

// File: rtl/fdc_exec_unit.sv
module fdc_exec_unit
  import fdc_seq_pkg::*;
#(
  parameter int CMD_DEPTH = 9,
  parameter int RES_DEPTH = 7,
  parameter int SECTORS   = 18,
  parameter int HEADS     = 2,
  parameter int CYLS      = 80
) (
  input  logic [4:0]            op,
  input  byte_t [CMD_DEPTH-1:0] cmd,
  input  logic [1:0]            drv,
  input  byte_t                 cyl,
  input  byte_t                 st0,
  output byte_t [RES_DEPTH-1:0] res,
  output byte_t                 st0_next,
  output byte_t                 cyl_next
);

  byte_t c_n, h_n, r_n;
  logic  unused_cmd;

  assign unused_cmd = ^cmd;

  // Geometry advance for the sector that follows the one addressed
  always_comb begin
    c_n = cmd[2];
    h_n = cmd[3];
    r_n = cmd[4] + 8'd1;
    if (r_n == byte_t'(SECTORS + 1)) begin
      r_n = 8'd1;
      h_n = cmd[3] + 8'd1;
      if (h_n == byte_t'(HEADS)) begin
        h_n = 8'd0;
        c_n = cmd[2] + 8'd1;
        if (c_n == byte_t'(CYLS)) c_n = 8'd0;
      end
    end
  end

  always_comb begin
    res      = '0;
    st0_next = st0;
    cyl_next = cyl;
    case (op)
      OP_SEEK: begin
        cyl_next = cmd[2];
        st0_next = ST0_SEEK_END;
      end
      OP_RECAL: begin
        st0_next = (cmd[1][1:0] == 2'd0) ? ST0_SEEK_END
                                         : (ST0_SEEK_END | ST0_ABNORMAL);
      end
      OP_SENSE_INT: begin
        st0_next = (drv == 2'd0) ? (ST0_INVALID | ST0_ABNORMAL)
                                 : (ST0_SEEK_END | ST0_ABNORMAL);
        res[0]   = st0_next;
        res[1]   = cyl;
      end
      OP_READ_ID: begin
        st0_next = 8'h00;
        res[3]   = cyl;
        res[5]   = 8'h01;
        res[6]   = 8'h02;
      end
      OP_READ_DATA: begin
        st0_next = 8'h00;
        res[3]   = c_n;
        res[4]   = h_n;
        res[5]   = r_n;
        res[6]   = cmd[5];
      end
      default: begin
        if (op_undefined(op)) begin
          st0_next = ST0_INVALID;
          res[0]   = ST0_INVALID;
        end else begin
          res[0]   = st0;
        end
      end
    endcase
  end

endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
  import fdc_seq_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int CMD_DEPTH = 9,
  parameter int RES_DEPTH = 7,
  parameter int SECTORS   = 18,
  parameter int HEADS     = 2,
  parameter int CYLS      = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              irq,
  output logic [1:0]        drive_sel,
  output logic [1:0]        motor_on,
  output logic              dma_irq_en
);

  localparam int IDX_W  = $clog2(CMD_DEPTH);
  localparam int RES_IW = $clog2(RES_DEPTH);
  localparam int LEN_W  = 4;
  localparam int OP_W   = 5;

  phase_t               phase_q;
  logic [IDX_W-1:0]     idx_q;
  logic [OP_W-1:0]      op_q;
  logic [1:0]           drv_q, motor_q;
  logic                 dma_q, soft_held_q, pin_held_q, irq_q;
  byte_t                st0_q, cyl_q;
  byte_t [RES_DEPTH-1:0] res_q;

  logic                 wr_dat, wr_ctrl, wr_pin, rd_dat;
  logic                 soft_fire, hard_fire, ph_reset;
  logic [OP_W-1:0]      tbl_op;
  logic [LEN_W-1:0]     tbl_clen, tbl_rlen;
  logic                 store_we;
  logic [IDX_W-1:0]     store_idx;
  byte_t [CMD_DEPTH-1:0] cmd_bytes;
  byte_t [RES_DEPTH-1:0] exe_res;
  byte_t                exe_st0, exe_cyl;
  byte_t                msr;

  assign wr_dat  = wr_en && (addr == ADDR_W'(PORT_DATA));
  assign wr_ctrl = wr_en && (addr == ADDR_W'(PORT_CTRL));
  assign wr_pin  = wr_en && (addr == ADDR_W'(PORT_PINRST));
  assign rd_dat  = rd_en && (addr == ADDR_W'(PORT_DATA));

  assign soft_fire = wr_ctrl && wr_data[2] && soft_held_q;
  assign hard_fire = wr_pin && !wr_data[6] && pin_held_q;
  assign ph_reset  = soft_fire || hard_fire;

  // Table lookup: opcode from the bus while idle, latched opcode after
  assign tbl_op = (phase_q == PH_IDLE) ? wr_data[OP_W-1:0] : op_q;

  fdc_op_table #(.OPS(32), .LEN_W(LEN_W), .OP_W(OP_W)) u_table (
    .op      (tbl_op),
    .cmd_len (tbl_clen),
    .res_len (tbl_rlen)
  );

  assign store_we  = wr_dat && ((phase_q == PH_IDLE) || (phase_q == PH_CMD));
  assign store_idx = (phase_q == PH_IDLE) ? '0 : idx_q;

  fdc_cmd_store #(.DEPTH(CMD_DEPTH), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .we      (store_we),
    .widx    (store_idx),
    .wdata   (wr_data),
    .bytes_o (cmd_bytes)
  );

  fdc_exec_unit #(
    .CMD_DEPTH (CMD_DEPTH),
    .RES_DEPTH (RES_DEPTH),
    .SECTORS   (SECTORS),
    .HEADS     (HEADS),
    .CYLS      (CYLS)
  ) u_exec (
    .op       (op_q),
    .cmd      (cmd_bytes),
    .drv      (drv_q),
    .cyl      (cyl_q),
    .st0      (st0_q),
    .res      (exe_res),
    .st0_next (exe_st0),
    .cyl_next (exe_cyl)
  );

  // Phase sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      op_q    <= '0;
      st0_q   <= '0;
      cyl_q   <= '0;
      res_q   <= '0;
    end else if (ph_reset) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      st0_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (wr_dat) begin
            op_q <= wr_data[OP_W-1:0];
            if (tbl_clen == LEN_W'(1)) begin
              phase_q <= PH_EXEC;
              idx_q   <= '0;
            end else begin
              phase_q <= PH_CMD;
              idx_q   <= IDX_W'(1);
            end
          end
        end
        PH_CMD: begin
          if (wr_dat) begin
            if (int'(idx_q) == int'(tbl_clen) - 1) begin
              phase_q <= PH_EXEC;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        PH_EXEC: begin
          res_q   <= exe_res;
          st0_q   <= exe_st0;
          cyl_q   <= exe_cyl;
          idx_q   <= '0;
          phase_q <= (tbl_rlen != '0) ? PH_RESULT : PH_IDLE;
        end
        default: begin
          if (rd_dat) begin
            if (int'(idx_q) == int'(tbl_rlen) - 1) begin
              phase_q <= PH_IDLE;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
      endcase
    end
  end

  // Control port, pin reset and interrupt flag
  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q       <= '0;
      motor_q     <= '0;
      dma_q       <= 1'b0;
      soft_held_q <= 1'b0;
      pin_held_q  <= 1'b0;
      irq_q       <= 1'b0;
    end else if (wr_ctrl) begin
      motor_q <= wr_data[5:4];
      dma_q   <= wr_data[3];
      drv_q   <= wr_data[1:0];
      if (!wr_data[2]) begin
        if (!soft_held_q) begin
          soft_held_q <= 1'b1;
          irq_q       <= 1'b0;
        end
      end else if (soft_held_q) begin
        soft_held_q <= 1'b0;
        irq_q       <= (wr_data[1:0] == 2'd0);
      end
    end else if (wr_pin) begin
      if (wr_data[6]) begin
        if (!pin_held_q) begin
          pin_held_q <= 1'b1;
          irq_q      <= 1'b0;
        end
      end else if (pin_held_q) begin
        pin_held_q <= 1'b0;
        drv_q      <= '0;
        motor_q    <= '0;
        dma_q      <= 1'b0;
      end
    end
  end

  assign msr = ((phase_q != PH_EXEC)   ? MSR_READY : 8'h00)
             | ((phase_q == PH_RESULT) ? MSR_DIN   : 8'h00)
             | ((phase_q != PH_IDLE)   ? MSR_BUSY  : 8'h00);

  // Registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (addr == ADDR_W'(PORT_DATA)) begin
        if (phase_q == PH_RESULT) rd_data <= res_q[idx_q[RES_IW-1:0]];
      end else if (addr == ADDR_W'(PORT_MSR)) begin
        rd_data <= msr;
      end else if (addr == ADDR_W'(PORT_IRQ)) begin
        rd_data <= irq_q ? 8'h40 : 8'h00;
      end else if (addr == ADDR_W'(PORT_DRQ)) begin
        rd_data <= 8'h40;
      end else begin
        rd_data <= 8'h00;
      end
    end
  end

  assign irq        = irq_q;
  assign drive_sel  = drv_q;
  assign motor_on   = motor_q;
  assign dma_irq_en = dma_q;

  // Assertions
  a_r3_exec_single_cycle: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_EXEC) |=> (phase_q != PH_EXEC));

  a_r4_exec_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_EXEC && wr_dat) |=> (phase_q != PH_CMD));

  a_r4_result_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_RESULT && wr_dat) |=> (phase_q == PH_RESULT) && $stable(idx_q));

  a_r5_result_index_in_range: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_RESULT) |-> (int'(idx_q) < int'(tbl_rlen)));

  a_r5_idle_read_holds: assert property (@(posedge clk) disable iff (rst)
    (rd_dat && !wr_en && phase_q != PH_RESULT) |=> $stable(rd_data));

  a_r7_seek_no_result: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_EXEC && op_q == OP_SEEK) |=> (phase_q == PH_IDLE));

  a_r11_irq_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(wr_ctrl && wr_data[2]));

  a_r12_pin_clears_irq: assert property (@(posedge clk) disable iff (rst)
    (wr_pin && wr_data[6] && !pin_held_q) |=> !irq_q);

endmodule

// File: tb/fdc_cmd_seq_test.sv
module fdc_cmd_seq_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;
  logic [1:0] drive_sel, motor_on;
  logic       dma_irq_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int m_cyl = 0;
  int m_st0 = 0;
  int m_drv = 0;

  always #5 clk = ~clk;

  fdc_cmd_seq uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
    .drive_sel(drive_sel), .motor_on(motor_on), .dma_irq_en(dma_irq_en)
  );

  function automatic int exp_clen(input int op);
    case (op)
      2, 5, 6, 9, 12, 17, 25, 29: return 9;
      3, 15: return 3;
      4, 7, 10: return 2;
      13: return 6;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_rlen(input int op);
    case (op)
      2, 5, 6, 9, 12, 17, 25, 29, 10, 13: return 7;
      3, 15, 7: return 0;
      8: return 2;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = 3'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic set_ctrl(input logic [7:0] d);
    wr(2, d);
    m_drv = int'(d[1:0]);
  endtask

  // Sends a full command, models its effect, reads and checks results
  task automatic run_cmd(input logic [7:0] b [9], input string req);
    int op = int'(b[0][4:0]);
    int cl = exp_clen(op);
    int rl = exp_rlen(op);
    logic [7:0] e [7];
    logic [7:0] got;
    int c, h, r;
    for (int k = 0; k < 7; k++) e[k] = 8'h00;
    case (op)
      15: begin m_cyl = int'(b[2]); m_st0 = 'h20; end
      7:  m_st0 = (b[1][1:0] == 2'd0) ? 'h20 : 'h60;
      8:  begin m_st0 = (m_drv == 0) ? 'hC0 : 'h60; e[0] = 8'(m_st0); e[1] = 8'(m_cyl); end
      10: begin m_st0 = 0; e[3] = 8'(m_cyl); e[5] = 8'h01; e[6] = 8'h02; end
      6: begin
        m_st0 = 0;
        c = int'(b[2]); h = int'(b[3]); r = int'(b[4]) + 1;
        if (r > 18) begin
          r = 1; h++;
          if (h > 1) begin h = 0; c++; if (c > 79) c = 0; end
        end
        e[3] = 8'(c); e[4] = 8'(h); e[5] = 8'(r); e[6] = b[5];
      end
      default: begin
        if (cl == 1 && rl == 1) begin m_st0 = 'h80; e[0] = 8'h80; end
        else e[0] = 8'(m_st0);
      end
    endcase
    for (int i = 0; i < cl; i++) begin
      wr(0, b[i]);
      if (i == 0 && cl > 1) begin
        rd(1, got);
        chk("R3", "status in command phase", got, 8'hA0);
      end
    end
    if (rl > 0) begin
      rd(1, got);
      chk("R3", "status in result phase", got, 8'hE0);
      for (int i = 0; i < rl; i++) begin
        rd(0, got);
        chk(req, $sformatf("op %02h result byte %0d", op, i), got, e[i]);
      end
    end
    rd(1, got);
    chk("R5", $sformatf("idle after op %02h", op), got, 8'h80);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, keep;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R13 status ports
    rd(1, got); chk("R1", "status after reset", got, 8'h80);
    rd(4, got); chk("R1", "irq port after reset", got, 8'h00);
    chk("R1", "irq pin", 8'(irq), 8'h00);
    chk("R1", "control outputs", {3'b0, dma_irq_en, motor_on, drive_sel}, 8'h00);
    rd(5, got); chk("R13", "transfer request port", got, 8'h40);
    rd(6, got); chk("R13", "unmapped port", got, 8'h00);

    // R6 undefined opcode, R2 high bits ignored
    run_cmd('{8'h00, 0, 0, 0, 0, 0, 0, 0, 0}, "R6");
    run_cmd('{8'hFF, 0, 0, 0, 0, 0, 0, 0, 0}, "R6");
    run_cmd('{8'h0F, 8'h00, 8'd37, 0, 0, 0, 0, 0, 0}, "R7");
    run_cmd('{8'hE8, 0, 0, 0, 0, 0, 0, 0, 0}, "R2");
    run_cmd('{8'h04, 8'h00, 0, 0, 0, 0, 0, 0, 0}, "R6");

    // R8 with drive 1, control fields R11
    set_ctrl(8'h0D);
    chk("R11", "control outputs", {3'b0, dma_irq_en, motor_on, drive_sel}, 8'h11);
    run_cmd('{8'h08, 0, 0, 0, 0, 0, 0, 0, 0}, "R8");
    run_cmd('{8'h07, 8'h01, 0, 0, 0, 0, 0, 0, 0}, "R7");
    run_cmd('{8'h04, 8'h01, 0, 0, 0, 0, 0, 0, 0}, "R6");
    run_cmd('{8'h07, 8'h00, 0, 0, 0, 0, 0, 0, 0}, "R7");
    run_cmd('{8'h04, 8'h00, 0, 0, 0, 0, 0, 0, 0}, "R6");

    // R9 geometry wraps, R10
    run_cmd('{8'h06, 0, 8'd5, 8'd0, 8'd3, 8'd2, 0, 0, 0}, "R9");
    run_cmd('{8'h06, 0, 8'd5, 8'd0, 8'd18, 8'd2, 0, 0, 0}, "R9");
    run_cmd('{8'h06, 0, 8'd5, 8'd1, 8'd18, 8'd2, 0, 0, 0}, "R9");
    run_cmd('{8'h06, 0, 8'd79, 8'd1, 8'd18, 8'd3, 0, 0, 0}, "R9");
    run_cmd('{8'h0A, 8'h00, 0, 0, 0, 0, 0, 0, 0}, "R10");
    run_cmd('{8'h0D, 0, 0, 0, 0, 0, 0, 0, 0}, "R6");

    // R3 execution cycle status and R4 write dropped during execution
    @(negedge clk); wr_en = 1; addr = 3'd0; wr_data = 8'h08;
    @(negedge clk); wr_en = 0; rd_en = 1; addr = 3'd1;
    @(negedge clk); rd_en = 0;
    chk("R3", "status in execution cycle", rd_data, 8'h20);
    rd(0, got); rd(0, got);
    rd(1, got); chk("R3", "idle after drain", got, 8'h80);
    @(negedge clk); wr_en = 1; addr = 3'd0; wr_data = 8'h08;
    @(negedge clk); wr_data = 8'h0F;
    @(negedge clk); wr_en = 0;
    rd(1, got); chk("R4", "exec-cycle write left result phase", got, 8'hE0);
    rd(0, got); chk("R4", "byte 0 after exec-cycle write", got, 8'h60);
    rd(0, got); chk("R4", "byte 1 after exec-cycle write", got, 8'd37);
    rd(1, got); chk("R4", "idle after exec-cycle write", got, 8'h80);

    // R4 write during result phase dropped
    wr(0, 8'h00);
    wr(0, 8'h08);
    rd(1, got); chk("R4", "result-phase write ignored", got, 8'hE0);
    rd(0, got); chk("R4", "result byte after dropped write", got, 8'h80);
    rd(1, got); chk("R4", "idle after single result", got, 8'h80);
    m_st0 = 'h80;

    // R5 data read with no pending result holds
    rd(4, keep);
    rd(0, got); chk("R5", "idle data read holds", got, keep);
    rd(1, got); chk("R5", "idle data read keeps phase", got, 8'h80);

    // R11 soft reset
    set_ctrl(8'h30);
    rd(4, got); chk("R11", "irq after reset low", got, 8'h00);
    set_ctrl(8'h34);
    chk("R11", "irq pin after soft reset drive 0", 8'(irq), 8'h01);
    rd(4, got); chk("R11", "irq port after soft reset", got, 8'h40);
    chk("R11", "motor outputs", 8'(motor_on), 8'h03);
    m_st0 = 0;
    run_cmd('{8'h04, 0, 0, 0, 0, 0, 0, 0, 0}, "R11");
    set_ctrl(8'h01);
    chk("R11", "irq cleared by reset low", 8'(irq), 8'h00);
    set_ctrl(8'h05);
    chk("R11", "no irq for drive 1", 8'(irq), 8'h00);
    wr(0, 8'h0F);
    set_ctrl(8'h00);
    set_ctrl(8'h04);
    rd(1, got); chk("R11", "soft reset aborts command", got, 8'h80);
    chk("R11", "irq after second soft reset", 8'(irq), 8'h01);
    m_st0 = 0;

    // R12 hard reset
    set_ctrl(8'h3D);
    wr(3, 8'h40);
    chk("R12", "pin reset clears irq", 8'(irq), 8'h00);
    wr(0, 8'h0F);
    wr(3, 8'h00);
    m_drv = 0; m_st0 = 0;
    rd(1, got); chk("R12", "hard reset aborts command", got, 8'h80);
    chk("R12", "control outputs cleared", {3'b0, dma_irq_en, motor_on, drive_sel}, 8'h00);
    run_cmd('{8'h04, 0, 0, 0, 0, 0, 0, 0, 0}, "R12");
    run_cmd('{8'h08, 0, 0, 0, 0, 0, 0, 0, 0}, "R8");

    // R2 random commands over all opcodes
    for (int n = 0; n < 300; n++) begin
      logic [7:0] b [9];
      if ($urandom % 8 == 0)
        set_ctrl({2'b00, 2'($urandom), 1'($urandom), 1'b1, 2'($urandom)});
      for (int k = 0; k < 9; k++) b[k] = 8'($urandom);
      if (b[0][4:0] == 5'h06) begin
        b[2] = 8'($urandom % 80);
        b[3] = 8'($urandom % 2);
        b[4] = 8'(1 + $urandom % 18);
      end
      run_cmd(b, "R2");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule